// File: doc/BRIEF.md
# Dithered 12-bit PWM Channel

This block is a single pulse-width-modulated output channel whose duty value is 12 bits wide. One output period lasts 4096 ticks and is cut into 16 subsections of 256 ticks each. In every subsection the output first goes high for a base width taken from the upper 8 bits of the duty value, then low for the rest of the subsection. The lower 4 bits act as a rate multiplier that chooses which subsections receive one extra tick of high time. The total high time per period then equals the duty value, and the energy is spread evenly over the period, so an external low-pass filter can turn the output into a smooth analog level.

Ticks come from a tick-enable input that the surrounding logic pulses at half the input clock rate, once every second clock. A duty value is captured on a load strobe and waits in a pending register. It becomes active only at the boundary between two periods, so a period that is already running always finishes with the value it started with. A start-of-cycle flag marks the first tick of each period that follows a counter wrap.

Top module: `dither_pwm`

## Requirements
- R1: Reset (rst_n low, asynchronous assertion) forces pwm_o and cycle_start_o low and clears both the pending and the active duty, so after release the output stays low until a value has been loaded and a period boundary has passed.
- R2: The period counter advances by one only in clock cycles with tick_en high, and one period is exactly 4096 ticks. pwm_o and cycle_start_o do not change after a clock edge at which tick_en was low.
- R3: In every subsection m (m = tick index within the period divided by 256), pwm_o is high for the first W ticks of the subsection and low for the rest, where W = duty[11:4] plus one if subsection m is lengthened.
- R4: Subsection m is lengthened when duty[3] is 1 and m is odd, when duty[2] is 1 and m mod 4 = 2, when duty[1] is 1 and m mod 8 = 4, or when duty[0] is 1 and m = 8. The total high time of a period then equals the 12-bit duty value.
- R5: Subsection 0 is never lengthened. Duty 0xFFF therefore gives 4095 high ticks, with 255 high ticks in subsection 0, and the output is never high for a whole period.
- R6: A value loaded while a period is running takes effect at the start of the next period. The running period completes with the old value.
- R7: When several loads occur within one period, the last one wins. A load in the same clock as the tick that wraps the counter from 4095 to 0 applies to the period that begins at that wrap.
- R8: cycle_start_o is high during exactly the first tick of each period that begins with a wrap from 4095 to 0, and low at every other tick. It stays low for the first period after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Tick enable, high for one clock in every two |
| duty_in | input | 12 | Duty value: [11:4] base width, [3:0] dither field |
| duty_load | input | 1 | Captures duty_in into the pending register |
| pwm_o | output | 1 | PWM level |
| cycle_start_o | output | 1 | High during the first tick of each period after a wrap |

## Verification
On every cycle the assertions check that the outputs hold between ticks, that the active duty changes only at the wrap tick, that the output is high below the base width and low above it, that the last tick of subsection 0 is always low, and that the start flag lasts one tick and coincides with count zero. Only the bench's scenarios can show the dither pattern itself: the per-subsection widths for each dither bit, a total high time equal to the duty value, the one-period delay of a new value, last-load-wins and the boundary load, and the clearing of a pending value by reset.

// File: rtl/dither_pwm_pkg.sv
package dither_pwm_pkg;
  // Default geometry: base pulse resolution and number of subsection index bits.
  localparam int unsigned BASE_W_DEF = 8;
  localparam int unsigned SUB_W_DEF  = 4;
endpackage

// File: rtl/dither_pwm_rst_sync.sv
module dither_pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dither_pwm_cnt.sv
module dither_pwm_cnt #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_q, start_d;
  logic             wrap;

  assign wrap = tick_en && (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d   = cnt_q;
    start_d = start_q;
    if (tick_en) begin
      cnt_d   = cnt_q + 1'b1;
      start_d = wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign wrap_o  = wrap;
  assign start_o = start_q;
endmodule

// File: rtl/dither_pwm_duty.sv
module dither_pwm_duty #(
  parameter int unsigned DUTY_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              wrap,
  output logic [DUTY_W-1:0] act_o
);
  logic [DUTY_W-1:0] pend_q, pend_d;
  logic [DUTY_W-1:0] act_q, act_d;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (load) pend_d = duty_in;
    if (wrap) act_d  = load ? duty_in : pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/dither_pwm_sel.sv
module dither_pwm_sel #(
  parameter int unsigned SUB_W = 4
) (
  input  logic [SUB_W-1:0] sub_idx,
  input  logic [SUB_W-1:0] dith,
  output logic             ext_o
);
  logic [SUB_W-1:0] hit;

  // Bit k of the subsection index being the lowest set bit selects dither
  // bit SUB_W-1-k; index 0 has no set bit and is never chosen.
  for (genvar k = 0; k < SUB_W; k++) begin : g_rate
    if (k == 0) begin : g_lsb
      assign hit[k] = dith[SUB_W-1] && sub_idx[0];
    end else begin : g_upper
      assign hit[k] = dith[SUB_W-1-k] && sub_idx[k] && (sub_idx[k-1:0] == '0);
    end
  end

  assign ext_o = |hit;
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import dither_pwm_pkg::*;
#(
  parameter int unsigned BASE_W = BASE_W_DEF,
  parameter int unsigned SUB_W  = SUB_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_en,
  input  logic [BASE_W+SUB_W-1:0] duty_in,
  input  logic                    duty_load,
  output logic                    pwm_o,
  output logic                    cycle_start_o
);
  localparam int unsigned DUTY_W = BASE_W + SUB_W;

  logic              rst_sync_n;
  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] act_duty;
  logic              wrap;
  logic              start;
  logic              ext;
  logic [BASE_W:0]   high_len;
  logic [BASE_W:0]   pos;

  dither_pwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dither_pwm_cnt #(.CNT_W(DUTY_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_en (tick_en),
    .cnt_o   (cnt_q),
    .wrap_o  (wrap),
    .start_o (start)
  );

  dither_pwm_duty #(.DUTY_W(DUTY_W)) u_duty (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (duty_load),
    .duty_in (duty_in),
    .wrap    (wrap),
    .act_o   (act_duty)
  );

  dither_pwm_sel #(.SUB_W(SUB_W)) u_sel (
    .sub_idx (cnt_q[DUTY_W-1:BASE_W]),
    .dith    (act_duty[SUB_W-1:0]),
    .ext_o   (ext)
  );

  always_comb begin
    high_len = {1'b0, act_duty[DUTY_W-1:SUB_W]} + {{BASE_W{1'b0}}, ext};
    pos      = {1'b0, cnt_q[BASE_W-1:0]};
  end

  assign pwm_o         = (pos < high_len);
  assign cycle_start_o = start;
endmodule

// File: rtl/dither_pwm_chk.sv
module dither_pwm_chk #(
  parameter int unsigned BASE_W = 8,
  parameter int unsigned SUB_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick_en,
  input logic [BASE_W+SUB_W-1:0] cnt_q,
  input logic [BASE_W+SUB_W-1:0] act_duty,
  input logic                    pwm_o,
  input logic                    cycle_start_o
);
  localparam int unsigned DUTY_W = BASE_W + SUB_W;
  localparam logic [DUTY_W-1:0] CNT_MAX = {DUTY_W{1'b1}};
  localparam logic [BASE_W-1:0] POS_MAX = {BASE_W{1'b1}};

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(pwm_o) && $stable(cycle_start_o)));

  // R6
  duty_swap_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_en && (cnt_q == CNT_MAX)) |=> $stable(act_duty));

  // R3
  high_below_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[BASE_W-1:0] < act_duty[DUTY_W-1:SUB_W]) |-> pwm_o);

  // R3
  low_above_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[BASE_W-1:0] > act_duty[DUTY_W-1:SUB_W]) |-> !pwm_o);

  // R5
  sub0_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q[DUTY_W-1:BASE_W] == '0) && (cnt_q[BASE_W-1:0] == POS_MAX)) |-> !pwm_o);

  // R8
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start_o |-> (cnt_q == '0));

  // R8
  start_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start_o && tick_en) |=> !cycle_start_o);
endmodule

bind dither_pwm dither_pwm_chk #(.BASE_W(BASE_W), .SUB_W(SUB_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .tick_en       (tick_en),
  .cnt_q         (cnt_q),
  .act_duty      (act_duty),
  .pwm_o         (pwm_o),
  .cycle_start_o (cycle_start_o)
);

// File: tb/test_dither_pwm.sv
`timescale 1ns/1ps
module test_dither_pwm;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic [11:0] duty_in;
  logic        duty_load;
  logic        pwm_o;
  logic        cycle_start_o;

  int checks;
  int fails;
  bit done;

  dither_pwm i_dither_pwm (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .duty_in       (duty_in),
    .duty_load     (duty_load),
    .pwm_o         (pwm_o),
    .cycle_start_o (cycle_start_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {load-at-boundary flag, duty}; the flag says how this entry is loaded.
  localparam int NVEC = 8;
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 12'h4A6}, {1'b0, 12'h000}, {1'b1, 12'h001}, {1'b0, 12'h00F},
    {1'b0, 12'hFFF}, {1'b1, 12'h963}, {1'b0, 12'h010}, {1'b0, 12'h008}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected high width of subsection m, from R3/R4/R5.
  function automatic int exp_width(input logic [11:0] d, input int m);
    int tz;
    int w;
    w = int'(d[11:4]);
    if (m != 0) begin
      tz = 0;
      while (((m >> tz) & 1) == 0) tz++;
      if (d[3 - tz]) w++;
    end
    return w;
  endfunction

  task automatic step();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic step_load(input logic [11:0] v);
    @(negedge clk); tick_en = 1'b1; duty_in = v; duty_load = 1'b1;
    @(negedge clk); tick_en = 1'b0; duty_load = 1'b0;
  endtask

  task automatic load(input logic [11:0] v);
    @(negedge clk); duty_in = v; duty_load = 1'b1;
    @(negedge clk); duty_load = 1'b0;
  endtask

  task automatic sync_start();
    while (!cycle_start_o) step();
  endtask

  // Observe one whole period that must use duty exp; load nxt during it.
  task automatic measure(input logic [11:0] exp, input logic [11:0] nxt, input bit at_bnd);
    int hi [16];
    int bad_shape;
    int bad_start;
    int bad_sub;
    int first_bad;
    int total;
    bit seen_low;
    for (int m = 0; m < 16; m++) hi[m] = 0;
    bad_shape = 0; bad_start = 0; bad_sub = 0; first_bad = -1; total = 0; seen_low = 0;
    for (int i = 0; i < 4096; i++) begin
      if ((i % 256) == 0) seen_low = 0;
      if (pwm_o) begin
        hi[i / 256]++;
        total++;
        if (seen_low) bad_shape++;
      end else begin
        seen_low = 1;
      end
      if (cycle_start_o != (i == 0)) bad_start++;
      if (!at_bnd && i == 50)  load(~nxt);
      if (!at_bnd && i == 100) load(nxt);
      if (at_bnd && i == 4095) step_load(nxt);
      else                     step();
    end
    for (int m = 0; m < 16; m++) begin
      if (hi[m] != exp_width(exp, m)) begin
        bad_sub++;
        if (first_bad < 0) first_bad = m;
      end
    end
    // R4 R6 R7: every subsection width matches the value active this period
    check(bad_sub == 0, $sformatf("R4/R6/R7 width sub%0d duty=%03h", first_bad, exp),
          (first_bad < 0) ? 0 : hi[first_bad],
          (first_bad < 0) ? 0 : exp_width(exp, first_bad));
    // R5: subsection 0 carries only the base width
    check(hi[0] == int'(exp[11:4]), $sformatf("R5 sub0 width duty=%03h", exp), hi[0], int'(exp[11:4]));
    // R4: total high time equals duty
    check(total == int'(exp), $sformatf("R4 total high duty=%03h", exp), total, int'(exp));
    // R3: high run then low within each subsection
    check(bad_shape == 0, $sformatf("R3 pulse shape duty=%03h", exp), bad_shape, 0);
    // R8: start flag only on tick 0
    check(bad_start == 0, $sformatf("R8 start flag duty=%03h", exp), bad_start, 0);
    // R2: 4096 ticks later the next period starts
    check(cycle_start_o == 1'b1, "R2 period length 4096", int'(cycle_start_o), 1);
  endtask

  initial begin
    logic p_hold, s_hold;
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; tick_en = 1'b0; duty_in = '0; duty_load = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs low in reset
    check(pwm_o == 1'b0 && cycle_start_o == 1'b0, "R1 reset outputs", int'({pwm_o, cycle_start_o}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8: no start flag in the first period after reset
    check(cycle_start_o == 1'b0, "R8 no start after reset", int'(cycle_start_o), 0);
    load(VEC[0][11:0]);
    step();
    // R1: loaded value not active before the first boundary
    check(pwm_o == 1'b0, "R1 low before first boundary", int'(pwm_o), 0);
    sync_start();

    for (int j = 0; j < NVEC; j++) begin
      logic [11:0] nxt;
      bit bnd;
      nxt = (j < NVEC - 1) ? VEC[j+1][11:0] : 12'h7FF;
      bnd = (j < NVEC - 1) ? VEC[j+1][12] : 1'b0;
      measure(VEC[j][11:0], nxt, bnd);
    end

    // Active value is now 0x7FF: base 127, subsection 0 high for ticks 0..126.
    repeat (30) step();
    p_hold = pwm_o; s_hold = cycle_start_o;
    repeat (10) @(negedge clk);
    // R2: nothing moves while tick_en stays low
    check(pwm_o == p_hold && cycle_start_o == s_hold && pwm_o == 1'b1,
          "R2 hold without ticks", int'({pwm_o, cycle_start_o}), int'({p_hold, s_hold}));

    load(12'hABC);
    @(negedge clk); rst_n = 1'b0;
    #1;
    // R1: asynchronous clear of the outputs
    check(pwm_o == 1'b0 && cycle_start_o == 1'b0, "R1 async reset outputs", int'({pwm_o, cycle_start_o}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sync_start();
    // R1: pending and active duty both cleared by reset
    measure(12'h000, 12'h000, 1'b0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule